// File: doc/BRIEF.md
# Scheduled Fp6 Multiplier

This block multiplies two elements of the cubic extension Fp6 = Fp2[v]/(v^3 - ξ), where Fp2 = Fp[i]/(i^2 + 1) and ξ = 1 + i. Each operand is given as three Fp2 coefficients, which is six Fp components. The modulus P is a small odd prime parameter. The product uses Karatsuba-style interpolation with six Fp2 products. Reduction by ξ is done with modular additions and subtractions, so no extra multiplication is needed.

The datapath keeps its hardware small. It has one pipelined Fp2 multiplier with a fixed latency and two Fp2 add/subtract units, all shared across a fixed microcoded schedule of nine steps. Each step does the following:
- It issues at most one Fp2 product, together with up to two independent additions or subtractions.
- It raises the Go line only on the units that the step uses and holds the clear line on the idle units.
- It advances only after every issued unit has reported completion.

Operand sums are formed in an earlier step than the product that consumes them. A client pulses `start` with both operands and waits for the one-cycle `done` pulse. The registered result then stays on `prod_out` until the next result replaces it.

Top module: `fp6_sched_mul`

## Requirements
- R1: While reset is asserted and after it is released, `busy` is 0, `done` is 0 and `prod_out` is all zero.
- R2: A `start` sampled while idle begins a multiplication. `busy` is high from the next cycle until the result is presented. `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R3: `prod_out` equals the product a·c in Fp6 = Fp2[v]/(v^3 - (1+i)) with i^2 = -1. The operand and result buses use the same layout: coefficient k of v^k occupies bits [2kW +: 2W], with its real part in the low W bits and its imaginary part in the high W bits.
- R4: A `start` that arrives while `busy` is high is ignored. The running multiplication finishes with the operands captured at its own start, and the completion time is unchanged.
- R5: `prod_out` changes only in a cycle where `done` is high. Changes on `a_in` or `c_in` without an accepted `start` do not change it.
- R6: The shared Fp2 multiplier returns each product exactly LAT cycles after it is issued. `done` rises exactly 6·(LAT+1)+8 clock cycles after the cycle in which `start` is sampled, which is 32 cycles for the default LAT of 3.
- R7: The shared Fp2 multiplier is never issued a new product while an earlier one is still in flight.
- R8: Every Fp component produced by the add/subtract units, by the multiplier and on `prod_out` lies in [0, P).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a multiplication when idle |
| a_in | input | 6*W | First operand, three Fp2 coefficients |
| c_in | input | 6*W | Second operand, three Fp2 coefficients |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse: `prod_out` was just updated |
| prod_out | output | 6*W | Registered Fp6 product |

## Verification
Two events can fall in the same cycle. The first is the late completion of the Fp2 product and the earlier-completed adder results written back in the same step; the schedule provokes this in every step that carries both a product and sums. A wrong latch of the adders' completion would corrupt operands, and this is judged by comparing every result with a bench model that uses schoolbook Fp6 multiplication. The second is a new `start` landing while a step is in progress. This is provoked by raising `start` with different operands at chosen cycles in the middle of a run, and it is judged by requiring that the original product and the exact completion time are unchanged.

// File: rtl/fp6_sched_pkg.sv
package fp6_sched_pkg;

   localparam int NUNIT    = 2;    // shared Fp2 add/sub units
   localparam int NSTEP    = 9;    // schedule length
   localparam int NMULSTEP = 6;    // steps that issue a product
   localparam int NREG     = 19;   // Fp2 scratch registers
   localparam int RIW      = $clog2(NREG);
   localparam int STW      = $clog2(NSTEP);

   typedef logic [RIW-1:0] ridx_t;

   // register file slots
   localparam ridx_t R_A0  = 0,  R_A1  = 1,  R_A2  = 2;
   localparam ridx_t R_C0  = 3,  R_C1  = 4,  R_C2  = 5;
   localparam ridx_t R_M11 = 6,  R_M12 = 7,  R_M22 = 8;
   localparam ridx_t R_M00 = 9,  R_M01 = 10, R_M02 = 11;
   localparam ridx_t R_SA  = 12, R_SB  = 13, R_SC  = 14, R_SD = 15;
   localparam ridx_t R_X   = 16, R_Y   = 17, R_Z   = 18;

   typedef enum logic [1:0] {OP_ADD, OP_SUB, OP_XI} uop_e;
   typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_FIN} st_e;

   typedef struct packed {
      logic                    mgo;
      ridx_t                   ma, mb, md;
      logic [NUNIT-1:0]        ugo;
      uop_e  [NUNIT-1:0]       uop;
      ridx_t [NUNIT-1:0]       ua, ub, ud;
   } ucode_t;

   function automatic ucode_t step_code(input logic [STW-1:0] s);
      ucode_t c;
      c = '0;
      case (s)
         0: begin
            c.mgo = 1'b1; c.ma = R_A1; c.mb = R_C1; c.md = R_M11; c.ugo = 2'b11;
            c.uop[0] = OP_ADD; c.ua[0] = R_A1; c.ub[0] = R_A2; c.ud[0] = R_SA;
            c.uop[1] = OP_ADD; c.ua[1] = R_C1; c.ub[1] = R_C2; c.ud[1] = R_SB;
         end
         1: begin
            c.mgo = 1'b1; c.ma = R_SA; c.mb = R_SB; c.md = R_M12; c.ugo = 2'b11;
            c.uop[0] = OP_ADD; c.ua[0] = R_A0; c.ub[0] = R_A1; c.ud[0] = R_SC;
            c.uop[1] = OP_ADD; c.ua[1] = R_C0; c.ub[1] = R_C1; c.ud[1] = R_SD;
         end
         2: begin
            c.mgo = 1'b1; c.ma = R_A2; c.mb = R_C2; c.md = R_M22; c.ugo = 2'b11;
            c.uop[0] = OP_SUB; c.ua[0] = R_M12; c.ub[0] = R_M11; c.ud[0] = R_X;
            c.uop[1] = OP_ADD; c.ua[1] = R_A0;  c.ub[1] = R_A2;  c.ud[1] = R_SA;
         end
         3: begin
            c.mgo = 1'b1; c.ma = R_A0; c.mb = R_C0; c.md = R_M00; c.ugo = 2'b11;
            c.uop[0] = OP_SUB; c.ua[0] = R_X;  c.ub[0] = R_M22; c.ud[0] = R_X;
            c.uop[1] = OP_ADD; c.ua[1] = R_C0; c.ub[1] = R_C2;  c.ud[1] = R_SB;
         end
         4: begin
            c.mgo = 1'b1; c.ma = R_SC; c.mb = R_SD; c.md = R_M01; c.ugo = 2'b11;
            c.uop[0] = OP_XI; c.ua[0] = R_X;   c.ud[0] = R_X;
            c.uop[1] = OP_XI; c.ua[1] = R_M22; c.ud[1] = R_Y;
         end
         5: begin
            c.mgo = 1'b1; c.ma = R_SA; c.mb = R_SB; c.md = R_M02; c.ugo = 2'b11;
            c.uop[0] = OP_ADD; c.ua[0] = R_X;   c.ub[0] = R_M00; c.ud[0] = R_X;
            c.uop[1] = OP_SUB; c.ua[1] = R_M11; c.ub[1] = R_M00; c.ud[1] = R_Z;
         end
         6: begin
            c.ugo = 2'b11;
            c.uop[0] = OP_SUB; c.ua[0] = R_Y; c.ub[0] = R_M11; c.ud[0] = R_Y;
            c.uop[1] = OP_SUB; c.ua[1] = R_Z; c.ub[1] = R_M22; c.ud[1] = R_Z;
         end
         7: begin
            c.ugo = 2'b11;
            c.uop[0] = OP_ADD; c.ua[0] = R_Y; c.ub[0] = R_M01; c.ud[0] = R_Y;
            c.uop[1] = OP_ADD; c.ua[1] = R_Z; c.ub[1] = R_M02; c.ud[1] = R_Z;
         end
         8: begin
            c.ugo = 2'b01;
            c.uop[0] = OP_SUB; c.ua[0] = R_Y; c.ub[0] = R_M00; c.ud[0] = R_Y;
         end
         default: c = '0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/fp_lane.sv
module fp_lane #(
   parameter int W = 8,
   parameter int P = 251
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] y
);
   localparam logic [W:0] PW = (W+1)'(P);

   logic [W:0] s;

   always_comb begin
      s = '0;
      if (!sub) begin
         s = {1'b0, a} + {1'b0, b};
         if (s >= PW) s = s - PW;
      end else if (a >= b) begin
         s = {1'b0, a} - {1'b0, b};
      end else begin
         s = {1'b0, a} + PW - {1'b0, b};
      end
      y = s[W-1:0];
   end
endmodule

// File: rtl/fp2_addsub_unit.sv
module fp2_addsub_unit
   import fp6_sched_pkg::*;
#(
   parameter int W = 8,
   parameter int P = 251
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go,
   input  logic           clr,
   input  uop_e           op,
   input  logic [2*W-1:0] x,
   input  logic [2*W-1:0] y,
   output logic [2*W-1:0] z,
   output logic           done
);
   logic [W-1:0] a0, b0, a1, b1, r0, r1;
   logic         s0, s1;

   // XI: (x0 - x1, x0 + x1) multiplies by 1 + i
   always_comb begin
      a0 = x[W-1:0];
      b0 = (op == OP_XI) ? x[2*W-1:W] : y[W-1:0];
      s0 = (op != OP_ADD);
      a1 = (op == OP_XI) ? x[W-1:0]   : x[2*W-1:W];
      b1 = (op == OP_XI) ? x[2*W-1:W] : y[2*W-1:W];
      s1 = (op == OP_SUB);
   end

   fp_lane #(.W(W), .P(P)) u_re (.a(a0), .b(b0), .sub(s0), .y(r0));
   fp_lane #(.W(W), .P(P)) u_im (.a(a1), .b(b1), .sub(s1), .y(r1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         z    <= '0;
         done <= 1'b0;
      end else begin
         done <= go;
         if (clr)     z <= '0;
         else if (go) z <= {r1, r0};
      end
   end

   a_r8_unit_range: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (z[W-1:0] < W'(P)) && (z[2*W-1:W] < W'(P)));
endmodule

// File: rtl/fp2_mul_pipe.sv
module fp2_mul_pipe #(
   parameter int W   = 8,
   parameter int P   = 251,
   parameter int LAT = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go,
   input  logic           clr,
   input  logic [2*W-1:0] x,
   input  logic [2*W-1:0] y,
   output logic [2*W-1:0] z,
   output logic           done
);
   localparam logic [2*W-1:0] PM  = (2*W)'(P);
   localparam int             LCW = $clog2(LAT+1) + 1;

   function automatic logic [W-1:0] fmul(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [2*W-1:0] pr, rm;
      pr = {{W{1'b0}}, a} * {{W{1'b0}}, b};
      rm = pr % PM;
      return rm[W-1:0];
   endfunction

   logic [W-1:0]   m00, m11, m01, m10, re, im;
   logic           vld [LAT];
   logic [2*W-1:0] dat [LAT];
   logic [LAT-1:0] vld_vec;

   assign m00 = fmul(x[W-1:0],   y[W-1:0]);
   assign m11 = fmul(x[2*W-1:W], y[2*W-1:W]);
   assign m01 = fmul(x[W-1:0],   y[2*W-1:W]);
   assign m10 = fmul(x[2*W-1:W], y[W-1:0]);

   // (x0 + x1 i)(y0 + y1 i) with i^2 = -1
   fp_lane #(.W(W), .P(P)) u_re (.a(m00), .b(m11), .sub(1'b1), .y(re));
   fp_lane #(.W(W), .P(P)) u_im (.a(m01), .b(m10), .sub(1'b0), .y(im));

   for (genvar g = 0; g < LAT; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld[0] <= 1'b0;
               dat[0] <= '0;
            end else begin
               vld[0] <= go & ~clr;
               if (go) dat[0] <= {im, re};
            end
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld[g] <= 1'b0;
               dat[g] <= '0;
            end else begin
               vld[g] <= vld[g-1] & ~clr;
               dat[g] <= dat[g-1];
            end
         end
      end
   end

   always_comb begin
      for (int k = 0; k < LAT; k++) vld_vec[k] = vld[k];
   end

   assign done = vld[LAT-1];
   assign z    = dat[LAT-1];

   // latency monitor for the checks below
   logic [LCW-1:0] lcnt;
   always_ff @(posedge clk) begin
      if (!rst_n)                                    lcnt <= '0;
      else if (go)                                   lcnt <= LCW'(1);
      else if (lcnt != '0 && lcnt < LCW'(LAT))       lcnt <= lcnt + 1'b1;
      else                                           lcnt <= '0;
   end

   a_r7_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> (vld_vec == '0));
   a_r7_onehot_pipe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(vld_vec));
   a_r6_mul_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lcnt == LCW'(LAT)));
   a_r8_mul_range: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (z[W-1:0] < W'(P)) && (z[2*W-1:W] < W'(P)));
endmodule

// File: rtl/fp6_sched_mul.sv
module fp6_sched_mul
   import fp6_sched_pkg::*;
#(
   parameter int W   = 8,
   parameter int P   = 251,
   parameter int LAT = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [6*W-1:0] a_in,
   input  logic [6*W-1:0] c_in,
   output logic           busy,
   output logic           done,
   output logic [6*W-1:0] prod_out
);
   localparam int FW      = 2*W;
   localparam int STEPCYC = NMULSTEP*(LAT+1) + (NSTEP-NMULSTEP)*2;

   initial begin : p_chk
      assert (P > 2 && P < (1 << W) && LAT >= 1 && W >= 2)
         else $error("fp6_sched_mul: bad parameters");
   end

   st_e            st;
   logic [STW-1:0] step_q;
   logic [FW-1:0]  rf [NREG];
   logic [NUNIT:0] seen, used, dn;
   logic           all_done;
   ucode_t         uc;

   logic [FW-1:0]    mz;
   logic             mdone, mgo, mclr;
   logic [FW-1:0]    uz [NUNIT];
   logic [NUNIT-1:0] udone;

   assign uc   = step_code(step_q);
   assign busy = (st != S_IDLE);

   assign mgo  = (st == S_ISSUE) & uc.mgo;
   assign mclr = busy & ~uc.mgo;

   fp2_mul_pipe #(.W(W), .P(P), .LAT(LAT)) u_mul (
      .clk(clk), .rst_n(rst_n), .go(mgo), .clr(mclr),
      .x(rf[uc.ma]), .y(rf[uc.mb]), .z(mz), .done(mdone));

   for (genvar u = 0; u < NUNIT; u++) begin : g_unit
      fp2_addsub_unit #(.W(W), .P(P)) u_as (
         .clk(clk), .rst_n(rst_n),
         .go((st == S_ISSUE) & uc.ugo[u]),
         .clr(busy & ~uc.ugo[u]),
         .op(uc.uop[u]), .x(rf[uc.ua[u]]), .y(rf[uc.ub[u]]),
         .z(uz[u]), .done(udone[u]));
   end

   assign used     = {uc.mgo, uc.ugo};
   assign dn       = {mdone, udone};
   assign all_done = &(~used | seen | dn);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         step_q   <= '0;
         seen     <= '0;
         done     <= 1'b0;
         prod_out <= '0;
         for (int k = 0; k < NREG; k++) rf[k] <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            S_IDLE: if (start) begin
               for (int k = 0; k < 3; k++) begin
                  rf[R_A0 + ridx_t'(k)] <= a_in[k*FW +: FW];
                  rf[R_C0 + ridx_t'(k)] <= c_in[k*FW +: FW];
               end
               step_q <= '0;
               st     <= S_ISSUE;
            end
            S_ISSUE: begin
               seen <= '0;
               st   <= S_WAIT;
            end
            S_WAIT: begin
               seen <= seen | dn;
               if (all_done) begin
                  if (uc.mgo) rf[uc.md] <= mz;
                  for (int u = 0; u < NUNIT; u++)
                     if (uc.ugo[u]) rf[uc.ud[u]] <= uz[u];
                  if (step_q == STW'(NSTEP-1)) st <= S_FIN;
                  else begin
                     step_q <= step_q + 1'b1;
                     st     <= S_ISSUE;
                  end
               end
            end
            S_FIN: begin
               prod_out <= {rf[R_Z], rf[R_Y], rf[R_X]};
               done     <= 1'b1;
               st       <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // cycles since the accepted start, for the timing checks
   logic [15:0] lat_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                    lat_q <= '0;
      else if (st == S_IDLE && start) lat_q <= '0;
      else if (busy)                 lat_q <= lat_q + 1'b1;
   end

   a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r2_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   a_r5_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(prod_out));
   a_r6_total_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_q == 16'(STEPCYC + 1)));
endmodule

// File: tb/tb_fp6_sched_mul.sv
`timescale 1ns/1ps
module tb_fp6_sched_mul;
   localparam int W       = 8;
   localparam int P       = 251;
   localparam int LAT     = 3;
   localparam int EXP_LAT = 6*(LAT+1) + 8;

   logic           clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [6*W-1:0] a_in = '0, c_in = '0, prod_out;
   logic           busy, done;
   int             checks = 0, fails = 0;

   fp6_sched_mul #(.W(W), .P(P), .LAT(LAT)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .c_in(c_in),
      .busy(busy), .done(done), .prod_out(prod_out));

   always #4 clk = ~clk;

   function automatic int fm(int x, int y); return (x*y) % P;     endfunction
   function automatic int fa(int x, int y); return (x+y) % P;     endfunction
   function automatic int fs(int x, int y); return (x-y+P) % P;   endfunction

   // schoolbook Fp6 product, v^3 = 1 + i
   function automatic logic [6*W-1:0] ref6(logic [6*W-1:0] av, logic [6*W-1:0] cv);
      int a[6], c[6], r[6];
      logic [6*W-1:0] o;
      for (int k = 0; k < 6; k++) begin
         a[k] = int'(av[k*W +: W]); c[k] = int'(cv[k*W +: W]); r[k] = 0;
      end
      for (int i = 0; i < 3; i++) begin
         for (int j = 0; j < 3; j++) begin
            int re, im, t, k;
            re = fs(fm(a[2*i], c[2*j]), fm(a[2*i+1], c[2*j+1]));
            im = fa(fm(a[2*i], c[2*j+1]), fm(a[2*i+1], c[2*j]));
            k  = i + j;
            if (k >= 3) begin
               t = re; re = fs(t, im); im = fa(t, im); k = k - 3;
            end
            r[2*k]   = fa(r[2*k], re);
            r[2*k+1] = fa(r[2*k+1], im);
         end
      end
      for (int k = 0; k < 6; k++) o[k*W +: W] = W'(r[k]);
      return o;
   endfunction

   function automatic logic [6*W-1:0] rnd_vec();
      logic [6*W-1:0] v;
      for (int k = 0; k < 6; k++) v[k*W +: W] = W'($urandom % P);
      return v;
   endfunction

   function automatic bit in_range(logic [6*W-1:0] v);
      for (int k = 0; k < 6; k++) if (int'(v[k*W +: W]) >= P) return 1'b0;
      return 1'b1;
   endfunction

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic do_mul(input logic [6*W-1:0] av, input logic [6*W-1:0] cv,
                         input int inj, output logic [6*W-1:0] res, output int lat);
      @(negedge clk);
      a_in = av; c_in = cv; start = 1'b1;
      @(negedge clk);
      start = 1'b0; lat = 1;
      chk("R2 busy after start", 64'(busy), 64'd1);
      while (!done && lat < 1000) begin
         if (lat == inj) begin
            a_in = rnd_vec(); c_in = rnd_vec(); start = 1'b1;
         end
         @(negedge clk);
         start = 1'b0; lat++;
      end
      res = prod_out;
      chk("R2 busy low with done", 64'(busy), 64'd0);
      @(negedge clk);
      chk("R2 done one cycle", 64'(done), 64'd0);
   endtask

   task automatic run_chk(input logic [6*W-1:0] av, input logic [6*W-1:0] cv,
                          input int inj, input string tag);
      logic [6*W-1:0] res;
      int lat;
      do_mul(av, cv, inj, res, lat);
      chk({tag, " product"}, 64'(res), 64'(ref6(av, cv)));
      chk("R8 result range", 64'(in_range(res)), 64'd1);
      chk("R6 R7 latency", 64'(lat), 64'(EXP_LAT));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [6*W-1:0] one_v, max_v, vv, v2, hold;
      int seed;
      seed = int'($urandom(32'd7));
      repeat (3) @(negedge clk);
      // R1 during reset
      chk("R1 busy in reset", 64'(busy), 64'd0);
      chk("R1 done in reset", 64'(done), 64'd0);
      chk("R1 prod in reset", 64'(prod_out), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after reset", 64'(busy), 64'd0);
      chk("R1 prod after reset", 64'(prod_out), 64'd0);

      one_v = '0; one_v[W-1:0] = W'(1);
      max_v = '0;
      for (int k = 0; k < 6; k++) max_v[k*W +: W] = W'(P-1);
      vv = '0; vv[2*W +: W] = W'(1);   // v
      v2 = '0; v2[4*W +: W] = W'(1);   // v^2

      run_chk('0, rnd_vec(), 0, "R3 zero");
      run_chk(one_v, max_v, 0, "R3 unit");
      run_chk(max_v, max_v, 0, "R3 all max");
      run_chk(vv, v2, 0, "R3 v times v2 gives xi");
      run_chk(v2, v2, 0, "R3 v2 squared");
      for (int n = 0; n < 30; n++) run_chk(rnd_vec(), rnd_vec(), 0, "R3 random");

      // R4: start pulses while busy, early and late in the run
      run_chk(rnd_vec(), rnd_vec(), 5,  "R4 start at cycle 5");
      run_chk(rnd_vec(), rnd_vec(), 20, "R4 start at cycle 20");
      run_chk(rnd_vec(), rnd_vec(), EXP_LAT-1, "R4 start at last busy cycle");

      // R5: result holds while inputs move without start
      hold = prod_out;
      for (int n = 0; n < 6; n++) begin
         a_in = rnd_vec(); c_in = rnd_vec();
         @(negedge clk);
         chk("R5 hold", 64'(prod_out), 64'(hold));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule